// File: doc/BRIEF.md
# Status LED and Button Controller

This controller turns a handful of node status flags into four LED enables and turns two active-low push-buttons into request pulses. Time comes from a single-cycle `tick_i` strobe (one millisecond per tick with the default parameters). Every duration (flash rate, blink rate, debounce span, press window) is a parameter counted in ticks.

The powerline LED and the Ethernet LED each show link presence. They flash at a fast rate (about 8 Hz) while traffic is seen on their channel. Each activity event keeps the flashing going for one full flash period after it. When the node runs as the network coordinator, the powerline LED stays steadily lit whatever the traffic. A mode LED mirrors a legacy-traffic flag. The power LED is lit when power is ready and flashes fast while firmware loads. When firmware is missing, the power LED blinks slowly with a one-second cycle.

Both buttons are synchronised and debounced. A debounced press of the pairing button yields a one-cycle pairing request. The factory-restore button is timed while held. On its debounced release, a one-cycle restore request is issued only if the hold lasted strictly between a lower and an upper bound (0.5 s and 3.0 s by default).

Top module: `stat_panel_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, all LED outputs and both request outputs are 0, given all flag inputs at 0 and both buttons released (1).
- R2: With no recent powerline activity, `led_plc_o` equals `plc_link_i`. Without link it is 0 regardless of activity or role.
- R3: Activity flashing uses a phase bit that is 0 after reset and toggles on every FLASH_HALF-th tick. An activity cycle loads a hold of 2*FLASH_HALF ticks, and each later tick decrements the hold. While the hold is non-zero and link is present, the LED shows the phase bit.
- R4: While `coord_i` is 1, `led_plc_o` equals `plc_link_i`, ignoring activity.
- R5: `led_eth_o` follows R2 and R3 using `eth_link_i` and `eth_act_i`, with the same shared phase bit.
- R6: With `fw_missing_i` at 0, `led_pwr_o` shows the fast phase bit when `fw_loading_i` is 1. Otherwise it equals `pwr_ready_i`.
- R7: With `fw_missing_i` at 1, `led_pwr_o` shows a slow phase bit. That bit is 0 after reset and toggles every BLINK_HALF ticks, overriding loading and ready.
- R8: `led_mode_o` equals `legacy_seen_i` delayed by one clock.
- R9: A button level change is accepted only after it has held for DEB_TICKS consecutive ticks. Shorter glitches produce no request.
- R10: Each accepted pairing-button press produces exactly one `pair_req_o` pulse of one cycle.
- R11: On accepted release of the restore button, `restore_req_o` pulses for one cycle if the debounced hold, counted in ticks, was greater than PRESS_MIN and less than PRESS_MAX.
- R12: Restore presses held PRESS_MIN ticks or fewer, or PRESS_MAX or more, produce no `restore_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-cycle time base strobe |
| plc_link_i | input | 1 | Powerline link present |
| plc_act_i | input | 1 | Powerline transmit/receive event |
| coord_i | input | 1 | Node acts as network coordinator |
| eth_link_i | input | 1 | Ethernet link present |
| eth_act_i | input | 1 | Ethernet transmit/receive event |
| legacy_seen_i | input | 1 | Legacy-protocol traffic seen |
| pwr_ready_i | input | 1 | Power ready |
| fw_loading_i | input | 1 | Firmware is loading |
| fw_missing_i | input | 1 | Firmware absent or corrupt |
| pair_btn_n_i | input | 1 | Pairing button, active low |
| restore_btn_n_i | input | 1 | Factory-restore button, active low |
| led_plc_o | output | 1 | Powerline LED enable |
| led_eth_o | output | 1 | Ethernet LED enable |
| led_mode_o | output | 1 | Legacy-mode LED enable |
| led_pwr_o | output | 1 | Power LED enable |
| pair_req_o | output | 1 | One-cycle pairing request |
| restore_req_o | output | 1 | One-cycle factory-restore request |

## Verification
The assertions assume the status flags are synchronous to `clk`. They also assume `tick_i` is never high in two successive cycles, so one accepted button change cannot be followed by another in the next cycle. The stimulus drives every input at the falling edge and pulses the tick on every fourth cycle. Button tests keep press lengths at least five ticks away from the window bounds, so that one tick of debounce skew cannot flip the expected outcome.

// File: rtl/stat_panel_pkg.sv
package stat_panel_pkg;

    typedef enum logic [1:0] {
        PWR_DARK,
        PWR_STEADY,
        PWR_FAST,
        PWR_SLOW
    } pwr_show_e;

    typedef struct packed {
        logic link;
        logic busy;
    } chan_view_t;

    typedef struct packed {
        logic plc;
        logic eth;
        logic mode;
        logic pwr;
    } led_set_t;

    // width of a counter holding values 0 .. n-1
    function automatic int ctr_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic pwr_show_e pick_pwr(input logic missing, input logic loading,
                                           input logic ready);
        if (missing)      return PWR_SLOW;
        else if (loading) return PWR_FAST;
        else if (ready)   return PWR_STEADY;
        else              return PWR_DARK;
    endfunction

    function automatic logic chan_led(input chan_view_t v, input logic phase,
                                      input logic steady);
        return v.link & (steady | ~v.busy | phase);
    endfunction

endpackage

// File: rtl/sp_tick_phase.sv
module sp_tick_phase #(
    parameter int HALF = 62
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    output logic phase_o
);
    localparam int W = stat_panel_pkg::ctr_w(HALF);
    localparam logic [W-1:0] LAST = W'(HALF - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            phase_o <= 1'b0;
        end else if (tick_i) begin
            if (cnt_q == LAST) begin
                cnt_q   <= '0;
                phase_o <= ~phase_o;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sp_act_stretch.sv
module sp_act_stretch #(
    parameter int SPAN = 124
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic act_i,
    output logic busy_o
);
    localparam int W = stat_panel_pkg::ctr_w(SPAN + 1);

    logic [W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)                        left_q <= '0;
        else if (act_i)                 left_q <= W'(SPAN);
        else if (tick_i && left_q != 0) left_q <= left_q - 1'b1;
    end

    assign busy_o = (left_q != '0);
endmodule

// File: rtl/sp_btn_filter.sv
module sp_btn_filter #(
    parameter int DEB_TICKS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic btn_n_i,
    output logic held_o,
    output logic flip_o
);
    localparam int W = stat_panel_pkg::ctr_w(DEB_TICKS);
    localparam logic [W-1:0] LAST = W'(DEB_TICKS - 1);

    logic [1:0]   sync_q;
    logic [W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            run_q  <= '0;
            held_o <= 1'b0;
            flip_o <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], ~btn_n_i};
            flip_o <= 1'b0;
            if (sync_q[1] == held_o) begin
                run_q <= '0;
            end else if (tick_i) begin
                if (run_q == LAST) begin
                    run_q  <= '0;
                    held_o <= sync_q[1];
                    flip_o <= 1'b1;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sp_hold_judge.sv
module sp_hold_judge #(
    parameter int PRESS_MIN = 500,
    parameter int PRESS_MAX = 3000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic held_i,
    input  logic flip_i,
    output logic fire_o
);
    localparam int W = stat_panel_pkg::ctr_w(PRESS_MAX + 1);
    localparam logic [W-1:0] CAP = W'(PRESS_MAX);
    localparam logic [W-1:0] LOW = W'(PRESS_MIN);

    logic [W-1:0] len_q;
    logic         let_go;

    assign let_go = flip_i & ~held_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q  <= '0;
            fire_o <= 1'b0;
        end else begin
            fire_o <= let_go && (len_q > LOW) && (len_q < CAP);
            if (!held_i)                     len_q <= '0;
            else if (tick_i && len_q != CAP) len_q <= len_q + 1'b1;
        end
    end
endmodule

// File: rtl/stat_panel_ctrl.sv
module stat_panel_ctrl
    import stat_panel_pkg::*;
#(
    parameter int DEB_TICKS  = 20,
    parameter int FLASH_HALF = 62,
    parameter int BLINK_HALF = 500,
    parameter int PRESS_MIN  = 500,
    parameter int PRESS_MAX  = 3000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic plc_link_i,
    input  logic plc_act_i,
    input  logic coord_i,
    input  logic eth_link_i,
    input  logic eth_act_i,
    input  logic legacy_seen_i,
    input  logic pwr_ready_i,
    input  logic fw_loading_i,
    input  logic fw_missing_i,
    input  logic pair_btn_n_i,
    input  logic restore_btn_n_i,
    output logic led_plc_o,
    output logic led_eth_o,
    output logic led_mode_o,
    output logic led_pwr_o,
    output logic pair_req_o,
    output logic restore_req_o
);
    localparam int NCHAN = 2;   // 0: powerline, 1: ethernet
    localparam int NBTN  = 2;   // 0: pairing,   1: restore
    localparam int SPAN  = 2 * FLASH_HALF;

    logic fast_ph, slow_ph;

    sp_tick_phase #(.HALF(FLASH_HALF)) fast_i (
        .clk(clk), .rst(rst), .tick_i(tick_i), .phase_o(fast_ph));
    sp_tick_phase #(.HALF(BLINK_HALF)) slow_i (
        .clk(clk), .rst(rst), .tick_i(tick_i), .phase_o(slow_ph));

    logic [NCHAN-1:0] link_v, act_v, busy_v;
    chan_view_t       view [NCHAN];

    assign link_v = {eth_link_i, plc_link_i};
    assign act_v  = {eth_act_i,  plc_act_i};

    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        sp_act_stretch #(.SPAN(SPAN)) stretch_i (
            .clk(clk), .rst(rst), .tick_i(tick_i),
            .act_i(act_v[c]), .busy_o(busy_v[c]));
        assign view[c] = '{link: link_v[c], busy: busy_v[c]};
    end

    logic [NBTN-1:0] btn_n_v, held_v, flip_v;
    assign btn_n_v = {restore_btn_n_i, pair_btn_n_i};

    for (genvar b = 0; b < NBTN; b++) begin : g_btn
        sp_btn_filter #(.DEB_TICKS(DEB_TICKS)) filt_i (
            .clk(clk), .rst(rst), .tick_i(tick_i), .btn_n_i(btn_n_v[b]),
            .held_o(held_v[b]), .flip_o(flip_v[b]));
    end

    sp_hold_judge #(.PRESS_MIN(PRESS_MIN), .PRESS_MAX(PRESS_MAX)) judge_i (
        .clk(clk), .rst(rst), .tick_i(tick_i),
        .held_i(held_v[1]), .flip_i(flip_v[1]), .fire_o(restore_req_o));

    assign pair_req_o = flip_v[0] & held_v[0];

    logic mode_q;
    always_ff @(posedge clk) begin
        if (rst) mode_q <= 1'b0;
        else     mode_q <= legacy_seen_i;
    end

    pwr_show_e pwr_sel;
    led_set_t  leds;

    always_comb begin
        pwr_sel   = pick_pwr(fw_missing_i, fw_loading_i, pwr_ready_i);
        leds.plc  = chan_led(view[0], fast_ph, coord_i);
        leds.eth  = chan_led(view[1], fast_ph, 1'b0);
        leds.mode = mode_q;
        unique case (pwr_sel)
            PWR_SLOW:   leds.pwr = slow_ph;
            PWR_FAST:   leds.pwr = fast_ph;
            PWR_STEADY: leds.pwr = 1'b1;
            default:    leds.pwr = 1'b0;
        endcase
    end

    assign led_plc_o  = leds.plc;
    assign led_eth_o  = leds.eth;
    assign led_mode_o = leds.mode;
    assign led_pwr_o  = leds.pwr;
endmodule

// File: rtl/stat_panel_chk.sv
module stat_panel_chk (
    input logic clk,
    input logic rst,
    input logic coord_i,
    input logic plc_link_i,
    input logic eth_link_i,
    input logic legacy_seen_i,
    input logic pwr_ready_i,
    input logic fw_loading_i,
    input logic fw_missing_i,
    input logic led_plc_o,
    input logic led_eth_o,
    input logic led_mode_o,
    input logic led_pwr_o,
    input logic pair_req_o,
    input logic restore_req_o,
    input logic restore_held
);
    assert_nolink_dark_R2: assert property (@(posedge clk) disable iff (rst)
        !plc_link_i |-> !led_plc_o);

    assert_coord_steady_R4: assert property (@(posedge clk) disable iff (rst)
        (coord_i && plc_link_i) |-> led_plc_o);

    assert_eth_dark_R5: assert property (@(posedge clk) disable iff (rst)
        !eth_link_i |-> !led_eth_o);

    assert_pwr_plain_R6: assert property (@(posedge clk) disable iff (rst)
        (!fw_missing_i && !fw_loading_i) |-> (led_pwr_o == pwr_ready_i));

    assert_mode_delay_R8: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (led_mode_o == $past(legacy_seen_i)));

    assert_pair_single_R10: assert property (@(posedge clk) disable iff (rst)
        pair_req_o |=> !pair_req_o);

    assert_restore_single_R11: assert property (@(posedge clk) disable iff (rst)
        restore_req_o |=> !restore_req_o);

    assert_restore_released_R11: assert property (@(posedge clk) disable iff (rst)
        restore_req_o |-> !restore_held);
endmodule

bind stat_panel_ctrl stat_panel_chk chk_i (
    .clk(clk), .rst(rst), .coord_i(coord_i), .plc_link_i(plc_link_i),
    .eth_link_i(eth_link_i), .legacy_seen_i(legacy_seen_i),
    .pwr_ready_i(pwr_ready_i), .fw_loading_i(fw_loading_i),
    .fw_missing_i(fw_missing_i), .led_plc_o(led_plc_o), .led_eth_o(led_eth_o),
    .led_mode_o(led_mode_o), .led_pwr_o(led_pwr_o), .pair_req_o(pair_req_o),
    .restore_req_o(restore_req_o), .restore_held(held_v[1]));

// File: tb/stat_panel_ctrl_tb.sv
module stat_panel_ctrl_tb_top;
    localparam int DEB = 3, FH = 4, BH = 10, PMIN = 20, PMAX = 60, TDIV = 4;

    logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
    logic plc_link = 0, plc_act = 0, coord = 0, eth_link = 0, eth_act = 0;
    logic legacy = 0, pwr_ready = 0, fw_loading = 0, fw_missing = 0;
    logic pair_n = 1, rest_n = 1;
    logic led_plc, led_eth, led_mode, led_pwr, pair_req, restore_req;

    always #10 clk = ~clk;   // 50 MHz

    stat_panel_ctrl #(.DEB_TICKS(DEB), .FLASH_HALF(FH), .BLINK_HALF(BH),
                      .PRESS_MIN(PMIN), .PRESS_MAX(PMAX)) dut_i (
        .clk(clk), .rst(rst), .tick_i(tick), .plc_link_i(plc_link),
        .plc_act_i(plc_act), .coord_i(coord), .eth_link_i(eth_link),
        .eth_act_i(eth_act), .legacy_seen_i(legacy), .pwr_ready_i(pwr_ready),
        .fw_loading_i(fw_loading), .fw_missing_i(fw_missing),
        .pair_btn_n_i(pair_n), .restore_btn_n_i(rest_n),
        .led_plc_o(led_plc), .led_eth_o(led_eth), .led_mode_o(led_mode),
        .led_pwr_o(led_pwr), .pair_req_o(pair_req), .restore_req_o(restore_req));

    int checks = 0, fails = 0, cyc = 0, pair_seen = 0, rest_seen = 0;

    // reference state built from R3, R5, R7, R8
    int m_fc, m_sc, m_hp, m_he;
    logic m_fp, m_sp, m_mode;

    always @(posedge clk) begin
        if (rst) begin
            m_fc <= 0; m_sc <= 0; m_hp <= 0; m_he <= 0;
            m_fp <= 0; m_sp <= 0; m_mode <= 0;
        end else begin
            if (tick) begin
                if (m_fc == FH - 1) begin m_fc <= 0; m_fp <= ~m_fp; end else m_fc <= m_fc + 1;
                if (m_sc == BH - 1) begin m_sc <= 0; m_sp <= ~m_sp; end else m_sc <= m_sc + 1;
            end
            if (plc_act) m_hp <= 2 * FH; else if (tick && m_hp != 0) m_hp <= m_hp - 1;
            if (eth_act) m_he <= 2 * FH; else if (tick && m_he != 0) m_he <= m_he - 1;
            m_mode <= legacy;
            if (pair_req) pair_seen <= pair_seen + 1;
            if (restore_req) rest_seen <= rest_seen + 1;
        end
    end

    always @(negedge clk) begin
        cyc  <= cyc + 1;
        tick <= ((cyc % TDIV) == TDIV - 1);
    end

    function automatic logic exp_chan(logic link, int hold, logic steady, logic ph);
        return link & (steady | (hold == 0) | ph);
    endfunction

    function automatic logic exp_pwr(logic miss, logic load, logic rdy, logic fp, logic sp);
        return miss ? sp : (load ? fp : rdy);
    endfunction

    task automatic chk(input string req, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at cycle %0d", req, act, expv, cyc);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            report();
        end
    end

    // compare all LEDs against the reference; inputs stable since last negedge
    task automatic cmp_leds;
        chk("R2/R3/R4 plc led", led_plc, exp_chan(plc_link, m_hp, coord, m_fp));
        chk("R5 eth led", led_eth, exp_chan(eth_link, m_he, 1'b0, m_fp));
        chk("R6/R7 pwr led", led_pwr, exp_pwr(fw_missing, fw_loading, pwr_ready, m_fp, m_sp));
        chk("R8 mode led", led_mode, m_mode);
    endtask

    task automatic run_rand(input int n, input int act_pct, input int pwr_pct);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmp_leds();
            plc_act <= ($urandom_range(99) < act_pct);
            eth_act <= ($urandom_range(99) < act_pct);
            if ($urandom_range(199) == 0) plc_link <= ~plc_link;
            if ($urandom_range(199) == 0) eth_link <= ~eth_link;
            if ($urandom_range(499) == 0) coord <= ~coord;
            if ($urandom_range(99) < 3) legacy <= ~legacy;
            if ($urandom_range(999) < pwr_pct) pwr_ready <= ~pwr_ready;
            if ($urandom_range(999) < pwr_pct) fw_loading <= ~fw_loading;
            if ($urandom_range(999) < pwr_pct) fw_missing <= ~fw_missing;
        end
        @(negedge clk);
        plc_act <= 0; eth_act <= 0;
    endtask

    // hold a button low for 'ticks' ticks then release and let it settle
    task automatic press(input bit which, input int ticks);
        @(negedge clk);
        if (which) rest_n <= 0; else pair_n <= 0;
        repeat (ticks * TDIV) @(negedge clk);
        if (which) rest_n <= 1; else pair_n <= 1;
        repeat ((DEB + 5) * TDIV) @(negedge clk);
    endtask

    initial begin
        int p0, r0;
        void'($urandom(32'h1c3d5e7f));
        repeat (6) @(negedge clk);
        // R1: outputs quiet during reset
        chk("R1 plc in reset", led_plc, 0); chk("R1 eth in reset", led_eth, 0);
        chk("R1 pwr in reset", led_pwr, 0); chk("R1 mode in reset", led_mode, 0);
        rst <= 0;
        @(negedge clk);
        chk("R1 pair after reset", pair_req, 0);
        chk("R1 restore after reset", restore_req, 0);
        cmp_leds();

        // directed: link with and without activity, coordinator role
        plc_link <= 1; eth_link <= 1;
        repeat (3) @(negedge clk);
        chk("R2 link steady", led_plc, 1);
        plc_act <= 1; eth_act <= 1; @(negedge clk); plc_act <= 0; eth_act <= 0;
        repeat (40) begin @(negedge clk); cmp_leds(); end
        coord <= 1; plc_act <= 1;
        repeat (20) begin @(negedge clk); chk("R4 coordinator steady", led_plc, 1); end
        plc_act <= 0; coord <= 0;
        fw_missing <= 1; fw_loading <= 1;
        repeat (100) begin @(negedge clk); cmp_leds(); end   // R7 slow blink wins
        fw_missing <= 0;
        repeat (40) begin @(negedge clk); cmp_leds(); end    // R6 fast flash

        // constrained random patterns
        run_rand(4000, 20, 5);
        run_rand(4000, 2, 2);
        run_rand(3000, 50, 20);

        // buttons: R9 glitch, R10 pairing, R11/R12 restore window
        p0 = pair_seen; press(0, 1);
        chk_int("R9 pair glitch ignored", pair_seen - p0, 0);
        r0 = rest_seen; press(1, 1);
        chk_int("R9 restore glitch ignored", rest_seen - r0, 0);
        p0 = pair_seen; press(0, 10);
        chk_int("R10 one pair pulse", pair_seen - p0, 1);
        p0 = pair_seen; press(0, 80);
        chk_int("R10 long press one pulse", pair_seen - p0, 1);
        r0 = rest_seen; press(1, PMIN - 5);
        chk_int("R12 short restore", rest_seen - r0, 0);
        r0 = rest_seen; press(1, PMIN + 5);
        chk_int("R11 restore near low bound", rest_seen - r0, 1);
        r0 = rest_seen; press(1, (PMIN + PMAX) / 2);
        chk_int("R11 restore mid window", rest_seen - r0, 1);
        r0 = rest_seen; press(1, PMAX - 5);
        chk_int("R11 restore near high bound", rest_seen - r0, 1);
        r0 = rest_seen; press(1, PMAX + 5);
        chk_int("R12 long restore", rest_seen - r0, 0);
        r0 = rest_seen; press(1, PMAX * 3);
        chk_int("R12 very long restore", rest_seen - r0, 0);
        p0 = pair_seen; press(1, PMIN + 10);
        chk_int("R10 restore button no pair", pair_seen - p0, 0);

        report();
    end
endmodule